// File: doc/BRIEF.md
# Bit Splice and Merge Unit

This execution unit inserts a field of one 32-bit word into another. It reads three operand values and writes one registered result. The destination operand is an input too, because every operation keeps part of it. Two splice operations build their bit mask from a count. Splice-right replaces the low N bits of the destination with the low N bits of the source. Splice-left replaces the high N bits of the destination with the high N bits of the source. The merge operation takes its mask directly from the third operand: it picks source bits where the mask is 1 and keeps destination bits where the mask is 0.

A caller presents an opcode, the three operand values and a valid strobe. One clock later the result and its valid flag appear at the registered outputs. The register file, instruction decode and hazard handling belong to the surrounding pipeline.

Top module: `bsm_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `res_valid` = 0 and `res_data` = 0 (synchronous, active-low reset).
- R2: When `in_valid` is high at a rising edge, `res_valid` is high after that edge and `res_data` carries the result of the operands sampled at that edge.
- R3: Opcode 2'b00 (splice-right) with count N gives the destination with its low N bits replaced by the low N bits of the source. For example, N=7, source 0, destination 0xFFFFFFFF gives 0xFFFFFF80.
- R4: Opcode 2'b01 (splice-left) with count N gives the destination with its high N bits replaced by the high N bits of the source.
- R5: Opcode 2'b10 (merge) gives (destination AND NOT ctl) OR (source AND ctl), bit by bit. For example, ctl 0x0007FF00, source 0xC5680CB2, destination 0x1AF7C1E8 gives 0x1AF00CE8.
- R6: Opcode 2'b11 returns the destination unchanged.
- R7: A splice with count 0 returns the destination unchanged.
- R8: A splice count of 32 to 63 acts as 32, so the result equals the whole source word.
- R9: A splice uses only bits [5:0] of `op_ctl` as its count. Bits [31:6] have no effect.
- R10: After an edge with `in_valid` low, `res_valid` is low and `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 2 | 00 splice-right, 01 splice-left, 10 merge, 11 pass destination |
| op_dst | input | 32 | Prior destination value |
| op_src | input | 32 | Source value |
| op_ctl | input | 32 | Splice count (bits [5:0]) or merge mask |
| res_valid | output | 1 | Result valid |
| res_data | output | 32 | Registered result |

## Verification
The assertions check these properties on every cycle: the valid flag follows the strobe one cycle late, the result holds while no strobe arrives, reset clears both outputs, merge results agree with the source wherever the mask is set, and pass-through, zero-count and saturated-count results equal the destination or source word. Only the bench's scenarios can confirm the exact splice field boundaries for each count in both directions. The same holds for the documented worked examples and for the count bits above bit 5 being ignored. The bench compares these against values that it computes by shifting.

// File: rtl/bsm_pkg.sv
// Package: shared opcode type and word width for the splice/merge unit.
// Assumes a two-bit opcode field supplied by the caller's decode.
package bsm_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_SPL_R = 2'b00,
        OP_SPL_L = 2'b01,
        OP_MERGE = 2'b10,
        OP_PASS  = 2'b11
    } bsm_op_e;
endpackage

// File: rtl/bsm_mask_gen.sv
// Builds a contiguous field mask of N ones from a count.
// LEFT=0 places the ones at the bottom of the word, LEFT=1 at the top.
// Assumes the count width can hold W; any count above W saturates to W.
module bsm_mask_gen #(
    parameter int W    = 32,
    parameter int CW   = 6,
    parameter bit LEFT = 1'b0
) (
    input  logic [CW-1:0] count,
    output logic [W-1:0]  mask
);
    int unsigned n_sat;

    // Saturate the count so that no shift by W or more can wrap.
    always_comb begin
        n_sat = (32'(count) > 32'(W)) ? 32'(W) : 32'(count);
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (LEFT) begin : g_hi
                // Bit i belongs to the top n_sat bits.
                always_comb mask[i] = (32'(i) + n_sat) >= 32'(W);
            end else begin : g_lo
                // Bit i belongs to the bottom n_sat bits.
                always_comb mask[i] = 32'(i) < n_sat;
            end
        end
    endgenerate
endmodule

// File: rtl/bsm_merge.sv
// Bitwise select: takes a source bit where sel is 1 and keeps the destination bit where sel is 0.
// Assumes all three operands have the same width.
module bsm_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    input  logic [W-1:0] sel,
    output logic [W-1:0] out
);
    // Merge the two words under the select mask.
    always_comb out = (dst & ~sel) | (src & sel);
endmodule

// File: rtl/bsm_unit.sv
// Top level of the splice/merge execution unit.
// It chooses a mask by opcode (a count-built low or high field, a direct mask, or none),
// merges the source into the destination under that mask and registers the result.
// Assumes the caller holds the operands stable only for the strobe cycle.
module bsm_unit
    import bsm_pkg::*;
#(
    parameter int W = bsm_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   opcode,
    input  logic [W-1:0] op_dst,
    input  logic [W-1:0] op_src,
    input  logic [W-1:0] op_ctl,
    output logic         res_valid,
    output logic [W-1:0] res_data
);
    localparam int CW = $clog2(W) + 1;

    bsm_op_e      op;
    logic [W-1:0] mask_lo;
    logic [W-1:0] mask_hi;
    logic [W-1:0] mask_sel;
    logic [W-1:0] merged;

    // Decode the raw opcode bits into the enum.
    always_comb op = bsm_op_e'(opcode);

    bsm_mask_gen #(.W(W), .CW(CW), .LEFT(1'b0)) u_mask_lo (
        .count (op_ctl[CW-1:0]),
        .mask  (mask_lo)
    );

    bsm_mask_gen #(.W(W), .CW(CW), .LEFT(1'b1)) u_mask_hi (
        .count (op_ctl[CW-1:0]),
        .mask  (mask_hi)
    );

    // Pick the field mask that matches the operation.
    always_comb begin
        unique case (op)
            OP_SPL_R: mask_sel = mask_lo;
            OP_SPL_L: mask_sel = mask_hi;
            OP_MERGE: mask_sel = op_ctl;
            default:  mask_sel = '0;
        endcase
    end

    bsm_merge #(.W(W)) u_merge (
        .dst (op_dst),
        .src (op_src),
        .sel (mask_sel),
        .out (merged)
    );

    // Register the result on a strobe and the valid flag on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_data <= merged;
        end
    end
endmodule

// File: rtl/bsm_unit_chk.sv
// Checker for bsm_unit: relates the registered outputs to the operands of the previous cycle.
// Assumes a 32-bit or wider word, so that the count field is bits [5:0].
module bsm_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   opcode,
    input logic [W-1:0] op_dst,
    input logic [W-1:0] op_src,
    input logic [W-1:0] op_ctl,
    input logic         res_valid,
    input logic [W-1:0] res_data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> res_valid == $past(in_valid));

    // R5
    merge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'b10) |=>
            ((res_data ^ $past(op_src)) & $past(op_ctl)) == '0);

    // R5
    merge_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'b10) |=>
            ((res_data ^ $past(op_dst)) & ~$past(op_ctl)) == '0);

    // R6
    pass_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'b11) |=> res_data == $past(op_dst));

    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opcode[1] && op_ctl[5:0] == 6'd0) |=> res_data == $past(op_dst));

    // R8
    sat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opcode[1] && op_ctl[5]) |=> res_data == $past(op_src));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res_data)));
endmodule

bind bsm_unit bsm_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .op_dst    (op_dst),
    .op_src    (op_src),
    .op_ctl    (op_ctl),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/sim_bsm_unit.sv
module sim_bsm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [31:0] op_dst = '0;
    logic [31:0] op_src = '0;
    logic [31:0] op_ctl = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bsm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .op_dst(op_dst), .op_src(op_src), .op_ctl(op_ctl),
        .res_valid(res_valid), .res_data(res_data)
    );

    // Reference model built from shifts, with the count saturated at 32.
    function automatic logic [31:0] ref_op(input logic [1:0] op, input logic [31:0] d,
                                           input logic [31:0] s, input logic [31:0] c);
        int n;
        n = int'(c[5:0]);
        if (n > 32) n = 32;
        case (op)
            2'b00: return (n == 0) ? d : (n == 32) ? s :
                          (((d >> n) << n) | ((s << (32 - n)) >> (32 - n)));
            2'b01: return (n == 0) ? d : (n == 32) ? s :
                          (((d << n) >> n) | ((s >> (32 - n)) << (32 - n)));
            2'b10: return (d & ~c) | (s & c);
            default: return d;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and check both outputs one cycle later.
    task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] d,
                          input logic [31:0] s, input logic [31:0] c, input logic [31:0] exp);
        @(negedge clk);
        opcode = op; op_dst = d; op_src = s; op_ctl = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check(req, res_data, exp);
    endtask

    initial begin
        logic [31:0] last;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 data", res_data, 32'd0);
        rst_n = 1'b1;

        // R3, R2: worked example for splice-right
        run_op("R3", 2'b00, 32'hFFFFFFFF, 32'h0, 32'd7, 32'hFFFFFF80);
        // R5: worked example for merge
        run_op("R5", 2'b10, 32'h1AF7C1E8, 32'hC5680CB2, 32'h0007FF00, 32'h1AF00CE8);
        // R4: splice-left with four bits
        run_op("R4", 2'b01, 32'h00000000, 32'hFFFFFFFF, 32'd4, 32'hF0000000);
        run_op("R4", 2'b01, 32'h12345678, 32'hABCDEF01, 32'd12, 32'hABC45678);
        // R6: pass-through ignores source and control
        run_op("R6", 2'b11, 32'hDEADBEEF, 32'h0F0F0F0F, 32'hFFFFFFFF, 32'hDEADBEEF);
        // R7: zero count in both directions
        run_op("R7", 2'b00, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'd0, 32'hA5A5A5A5);
        run_op("R7", 2'b01, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'd0, 32'hA5A5A5A5);
        // R8: counts 32 and 63 copy the whole source
        run_op("R8", 2'b00, 32'h11111111, 32'h87654321, 32'd32, 32'h87654321);
        run_op("R8", 2'b01, 32'h11111111, 32'h87654321, 32'd63, 32'h87654321);
        // R9: upper count bits ignored (64 acts as 0, 0xFFFFFF47 acts as 7)
        run_op("R9", 2'b00, 32'hCAFEF00D, 32'h12345678, 32'd64, 32'hCAFEF00D);
        run_op("R9", 2'b00, 32'hFFFFFFFF, 32'h0, 32'hFFFFFF47, 32'hFFFFFF80);
        run_op("R9", 2'b01, 32'h0, 32'hFFFFFFFF, 32'h80000001, 32'h80000000);

        // R10: no strobe leaves the result and drops valid
        last = res_data;
        @(negedge clk);
        opcode = 2'b10; op_dst = 32'h0; op_src = 32'hFFFFFFFF; op_ctl = 32'hFFFFFFFF;
        @(negedge clk);
        check("R10 valid", 32'(res_valid), 32'd0);
        check("R10 data", res_data, last);

        // R2, R3, R4, R5, R6: random mix against the shift model
        for (int k = 0; k < 400; k++) begin
            logic [1:0]  op;
            logic [31:0] d, s, c;
            op = 2'($urandom());
            d = $urandom(); s = $urandom(); c = $urandom();
            if (!op[1] && (k % 2 == 0)) c = {26'h0, 6'($urandom_range(0, 33))};
            run_op("R2/R3/R4/R5/R6 random", op, d, s, c, ref_op(op, d, s, c));
        end

        // R1: reset in mid-run clears outputs
        @(negedge clk);
        opcode = 2'b11; op_dst = 32'h77777777; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 mid valid", 32'(res_valid), 32'd0);
        check("R1 mid data", res_data, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule